// File: doc/BRIEF.md
# Dual-Mode 16-bit Pulse Accumulator

This block keeps a 16-bit accumulator driven by a single external input pin. The accumulator works in one of two modes. In event mode it adds one for every selected transition of the pin. In gated mode it adds one per period of a bus clock divided by 64, for as long as the pin holds its active level. A single polarity bit has two meanings. In event mode it chooses the counted transition. In gated mode it chooses the active level, and the transition that ends an active window raises the edge flag.

Software reaches the block through a small byte-wide register bus with four locations. The first holds the control bits and the second holds the two write-one-to-clear flags. The last two hold the high and low bytes of the count. A byte-wide access to the count stays coherent when the high byte goes first. Each of the two interrupt outputs is its flag gated by its own enable. The pin passes through a two-flop synchronizer before any edge or level decision. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register, flag register, count and both interrupt outputs are all zero.
- R2: The control register at address 0 can be read and written at any time. Its bits are [6] enable, [5] mode (0 event, 1 gated), [4] polarity, [3:2] clock select (stored only), [1] overflow interrupt enable and [0] edge interrupt enable. Bit 7 always reads 0.
- R3: With enable at 0 the count and both flags stay unchanged, whatever the mode bit, the pin edges or the pin level.
- R4: In event mode, polarity 0 adds one to the count on each falling pin edge and polarity 1 adds one on each rising edge. Edges of the other direction are not counted.
- R5: In gated mode the count rises by one per 64 bus clocks while the pin is at its active level: high for polarity 0, low for polarity 1. A window of exactly 64*N clocks adds exactly N.
- R6: The edge flag (bit 6 of address 1) is set by each counted edge in event mode. In gated mode it is set by the edge that ends the active window: falling for polarity 0, rising for polarity 1.
- R7: A count step from 0xFFFF to 0x0000 sets the overflow flag (bit 7 of address 1).
- R8: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves it as it was.
- R9: The edge interrupt output equals edge flag AND control bit 0. The overflow interrupt output equals overflow flag AND control bit 1.
- R10: A read of the count high byte (address 2) captures the low byte. The next read of address 3 returns that captured value even if the count has moved since.
- R11: A write to address 2 is held and does not change the count. A following write to address 3 loads the held high byte and the new low byte together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External accumulator input, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address: 0 control, 1 flags, 2 count high, 3 count low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_edge | output | 1 | Edge interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Event mode is driven with trains of full pulses under both polarities. Because every pulse has one rising and one falling edge, the result shows that only one direction is counted. Gated mode is driven with windows whose length is an exact multiple of 64 clocks under both polarities. An exact count shows that the prescaler samples the synchronized level rather than edges, and the flag check tells the leading edge of a window from the trailing edge. The disabled run holds the pin at the gated active level and also toggles it, so that neither path can leak. The coherency runs move the count between the two byte reads and between the two byte writes.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CHI  = 2'd2;
  localparam logic [1:0] ADDR_CLO  = 2'd3;

  localparam int FLAG_OVF_BIT  = 7;
  localparam int FLAG_EDGE_BIT = 6;

  typedef struct packed {
    logic       enable;
    logic       gated;
    logic       polarity;
    logic [1:0] clk_sel;
    logic       ovf_ie;
    logic       edge_ie;
  } ctrl_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // R4: at most one edge direction per cycle
  a_r4_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = &cnt_q;

  // R5: the divided clock enable is a single-cycle pulse
  a_r5_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pa_core.sv
module pa_core
  import pa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_edge,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic             edge_flag,
  output logic             ovf_flag
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             edge_q, edge_d, ovf_q, ovf_d;
  logic             sel_edge, gate_on, inc, edge_set, ovf_set;

  always_comb begin
    sel_edge = ctrl.polarity ? rise : fall;
    gate_on  = level ^ ctrl.polarity;
    inc      = ctrl.enable & (ctrl.gated ? (tick & gate_on) : sel_edge);
    edge_set = ctrl.enable & sel_edge;
    ovf_set  = inc & (&count_q) & ~cnt_wr;

    if (cnt_wr)   count_d = cnt_wdata;
    else if (inc) count_d = count_q + 1'b1;
    else          count_d = count_q;

    edge_d = edge_set | (edge_q & ~clr_edge);
    ovf_d  = ovf_set  | (ovf_q  & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      edge_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      edge_q  <= edge_d;
      ovf_q   <= ovf_d;
    end
  end

  assign count     = count_q;
  assign edge_flag = edge_q;
  assign ovf_flag  = ovf_q;

  // R3: disabled accumulator holds its count
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !cnt_wr) |=> (count_q == $past(count_q)));

  // R5: without a bus write the count moves by at most one per cycle
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

  // R7: a wrap sets the overflow flag
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&count_q && inc && !cnt_wr) |=> (ovf_q && count_q == '0));

  // R8: clearing with no concurrent set leaves the flag low
  a_r8_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !edge_set) |=> !edge_q);
endmodule

// File: rtl/pa_regs.sv
module pa_regs
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              edge_flag,
  input  logic              ovf_flag,
  output ctrl_t             ctrl,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              clr_edge,
  output logic              clr_ovf
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] hi_hold_q, hi_hold_d, lo_hold_q, lo_hold_d;
  logic              wr_ctrl, wr_flag, wr_hi, wr_lo, rd_hi;

  always_comb begin
    wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    wr_flag = bus_sel & bus_wr & (bus_addr == ADDR_FLAG);
    wr_hi   = bus_sel & bus_wr & (bus_addr == ADDR_CHI);
    wr_lo   = bus_sel & bus_wr & (bus_addr == ADDR_CLO);
    rd_hi   = bus_sel & ~bus_wr & (bus_addr == ADDR_CHI);

    ctrl_d    = wr_ctrl ? ctrl_t'(bus_wdata[6:0]) : ctrl_q;
    hi_hold_d = wr_hi ? bus_wdata : hi_hold_q;
    lo_hold_d = rd_hi ? count[BYTE_W-1:0] : lo_hold_q;

    cnt_wr    = wr_lo;
    cnt_wdata = {hi_hold_q, bus_wdata};
    clr_ovf   = wr_flag & bus_wdata[FLAG_OVF_BIT];
    clr_edge  = wr_flag & bus_wdata[FLAG_EDGE_BIT];

    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {1'b0, ctrl_q};
      ADDR_FLAG: begin
        bus_rdata[FLAG_OVF_BIT]  = ovf_flag;
        bus_rdata[FLAG_EDGE_BIT] = edge_flag;
      end
      ADDR_CHI:  bus_rdata = count[CNT_W-1:BYTE_W];
      default:   bus_rdata = lo_hold_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hi_hold_q <= '0;
      lo_hold_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      hi_hold_q <= hi_hold_d;
      lo_hold_q <= lo_hold_d;
    end
  end

  assign ctrl = ctrl_q;

  // R11: a high-byte write alone never touches the count
  a_r11_hi_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> !cnt_wr);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_edge,
  output logic              irq_ovf
);
  logic             rst_meta_q, rst_q;
  ctrl_t            ctrl;
  logic             level, rise, fall, tick;
  logic             cnt_wr, clr_edge, clr_ovf, edge_flag, ovf_flag;
  logic [CNT_W-1:0] cnt_wdata, count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .pin(pin_in),
    .level(level), .rise(rise), .fall(fall)
  );

  pa_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_q), .tick(tick)
  );

  pa_regs u_regs (
    .clk(clk), .rst_n(rst_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
    .ctrl(ctrl), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  pa_core u_core (
    .clk(clk), .rst_n(rst_q), .ctrl(ctrl),
    .level(level), .rise(rise), .fall(fall), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .count(count), .edge_flag(edge_flag), .ovf_flag(ovf_flag)
  );

  assign irq_edge = edge_flag & ctrl.edge_ie;
  assign irq_ovf  = ovf_flag & ctrl.ovf_ie;

  // R9: no interrupt request without its enable bit
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_q)
    (!ctrl.edge_ie |-> !irq_edge) and (!ctrl.ovf_ie |-> !irq_ovf));
endmodule

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_edge, irq_ovf;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  pulse_accum u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_edge(irq_edge), .irq_ovf(irq_ovf)
  );

  localparam logic [7:0] C_EN = 8'h40, C_GATE = 8'h20, C_POL = 8'h10;
  localparam logic [7:0] C_OVIE = 8'h02, C_EDIE = 8'h01;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(2'd2, h);
    bus_read(2'd3, l);
    v = {h, l};
  endtask

  task automatic set_count(input logic [15:0] v);
    bus_write(2'd2, v[15:8]);
    bus_write(2'd3, v[7:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_in = ~pin_in; idle(4);
      pin_in = ~pin_in; idle(4);
    end
    idle(4);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] v;
    bus_read(2'd0, d); check("R1 ctrl", {8'h0, d}, 16'h0);
    bus_read(2'd1, d); check("R1 flags", {8'h0, d}, 16'h0);
    read_count(v);     check("R1 count", v, 16'h0);
    check("R1 irqs", {14'h0, irq_edge, irq_ovf}, 16'h0);
  endtask

  task automatic t_ctrl_rw;
    logic [7:0] d;
    bus_write(2'd0, 8'hBF);
    bus_read(2'd0, d); check("R2 ctrl readback bit7 zero", {8'h0, d}, 16'h003F);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d); check("R2 ctrl cleared", {8'h0, d}, 16'h0);
  endtask

  task automatic t_disabled;
    logic [7:0] d; logic [15:0] v;
    bus_write(2'd0, C_GATE);
    set_count(16'h0042);
    pulses(3);
    pin_in = 1'b1; idle(200); pin_in = 1'b0; idle(6);
    read_count(v);     check("R3 count held when disabled", v, 16'h0042);
    bus_read(2'd1, d); check("R3 no flags when disabled", {8'h0, d}, 16'h0);
  endtask

  task automatic t_event;
    logic [7:0] d; logic [15:0] v;
    bus_write(2'd0, C_EN);
    set_count(16'h0000);
    bus_write(2'd1, 8'hC0);
    pulses(5);
    read_count(v);     check("R4 falling edges counted", v, 16'd5);
    bus_read(2'd1, d); check("R6 edge flag event mode", {8'h0, d}, 16'h0040);
    bus_write(2'd0, C_EN | C_POL);
    set_count(16'h0000);
    bus_write(2'd1, 8'h40);
    pulses(3);
    read_count(v);     check("R4 rising edges counted", v, 16'd3);
  endtask

  task automatic t_gated;
    logic [7:0] d; logic [15:0] v;
    pin_in = 1'b0;
    bus_write(2'd0, C_EN | C_GATE);
    set_count(16'h0000);
    bus_write(2'd1, 8'hC0);
    @(negedge clk); pin_in = 1'b1;
    idle(64 * 3);
    bus_read(2'd1, d); check("R6 no flag on leading edge", {8'h0, d}, 16'h0);
    pin_in = 1'b0; idle(6);
    read_count(v);     check("R5 gated high 3 periods", v, 16'd3);
    bus_read(2'd1, d); check("R6 flag on trailing fall", {8'h0, d}, 16'h0040);
    bus_write(2'd0, 8'h00);
    pin_in = 1'b1; idle(6);
    bus_write(2'd0, C_EN | C_GATE | C_POL);
    set_count(16'h0000);
    bus_write(2'd1, 8'hC0);
    @(negedge clk); pin_in = 1'b0;
    idle(64 * 2);
    pin_in = 1'b1; idle(6);
    read_count(v);     check("R5 gated low 2 periods", v, 16'd2);
    bus_read(2'd1, d); check("R6 flag on trailing rise", {8'h0, d}, 16'h0040);
    pin_in = 1'b1; idle(64 * 2);
    read_count(v);     check("R5 inactive level no count", v, 16'd2);
    bus_write(2'd0, 8'h00);
    pin_in = 1'b0; idle(6);
  endtask

  task automatic t_overflow;
    logic [7:0] d; logic [15:0] v;
    bus_write(2'd0, C_EN);
    bus_write(2'd1, 8'hC0);
    set_count(16'hFFFE);
    pulses(2);
    read_count(v);     check("R7 wrapped count", v, 16'h0000);
    bus_read(2'd1, d); check("R7 overflow flag", {8'h0, d}, 16'h00C0);
    check("R9 irqs off without enable", {14'h0, irq_edge, irq_ovf}, 16'h0);
    bus_write(2'd0, C_EN | C_OVIE);
    idle(1);
    check("R9 irq_ovf with enable", {14'h0, irq_edge, irq_ovf}, 16'h1);
    bus_write(2'd0, C_EN | C_EDIE);
    idle(1);
    check("R9 irq_edge with enable", {14'h0, irq_edge, irq_ovf}, 16'h2);
    bus_write(2'd1, 8'h80);
    bus_read(2'd1, d); check("R8 clear overflow only", {8'h0, d}, 16'h0040);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R8 zero write keeps flag", {8'h0, d}, 16'h0040);
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, d); check("R8 clear edge", {8'h0, d}, 16'h0);
    check("R9 irq_edge drops", {14'h0, irq_edge, irq_ovf}, 16'h0);
  endtask

  task automatic t_coherent;
    logic [7:0] h, l; logic [15:0] v;
    bus_write(2'd0, C_EN);
    set_count(16'h12FF);
    bus_read(2'd2, h);
    pulses(1);
    bus_read(2'd3, l);
    check("R10 latched pair", {h, l}, 16'h12FF);
    read_count(v);  check("R10 fresh pair", v, 16'h1300);
    bus_write(2'd2, 8'hAB);
    read_count(v);  check("R11 high write held", v, 16'h1300);
    bus_write(2'd3, 8'hCD);
    read_count(v);  check("R11 pair loaded", v, 16'hABCD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_ctrl_rw;
    t_disabled;
    t_event;
    t_gated;
    t_overflow;
    t_coherent;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule